// File: doc/BRIEF.md
# Home-node directory coherence controller

This block sits at the home node of a small shared-memory group and keeps one directory entry per memory block. Each entry holds a three-valued state (uncached, shared, exclusive) and a presence vector with one bit per processor node. Nodes send it read misses, write misses and eviction notices. It answers by sending invalidate or fetch commands to the caches that hold the block, collecting their acknowledgements, updating the entry and its backing memory word, and then signalling completion to the requester with the block's data.

Writes are handled by invalidation. Before a writer is granted exclusive ownership, every other holder of the block is told to drop its copy, and the controller waits for each of those holders to acknowledge. A dirty block held exclusively is brought back to memory before anyone else sees it. Because of this, all nodes observe writes to a block in one order.

The controller runs one transaction at a time. A request presented while an earlier one is still open is held off through the ready handshake until that earlier one has completed. The caches and the interconnect are outside the block. Commands leave as per-node bit vectors, and acknowledgements return the same way.

Top module: `dircoh_home`

## Requirements
- R1: After reset, `req_ready` is 1, `inv_vec`, `fetch_vec` and `done_valid` are 0, every block is uncached, and every memory word reads as zero.
- R2: A read miss (`req_op` = 0) on an uncached or shared block issues no command, completes with the memory word, and adds the requester to the block's holders in the shared state.
- R3: A read miss on a block held exclusively by another node drives `fetch_vec` one-hot at the owner. The owner's `ack_data` is written to memory and returned as `done_data`. The block becomes shared, with both the owner and the requester as holders.
- R4: A write miss (`req_op` = 1) drives `inv_vec` for one cycle with exactly the holders other than the requester. No other invalidate is sent during that transaction.
- R5: A write miss on a block held exclusively by another node takes the owner's `ack_data` into memory and returns it as `done_data`.
- R6: After a write miss completes, the block is exclusive with the requester as its only holder. A write miss that has no other holder completes with no command and with the memory word.
- R7: An eviction (`req_op` = 2) by the exclusive owner writes `req_data` to memory and makes the block uncached.
- R8: An eviction by one sharer removes only that node from the holders. The block becomes uncached once no holder remains.
- R9: An eviction by a node that does not hold the block completes and leaves the entry and the memory unchanged.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its `done_valid`. Requests are served one at a time.
- R11: Every accepted request produces exactly one single-cycle `done_valid` pulse carrying the requester's node and block address.
- R12: Completion waits until every commanded node has pulsed its bit on `ack_vec`. The acknowledgements may arrive in any cycles and in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_node | input | NID_W | Requesting node |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 eviction |
| req_addr | input | AW | Block index |
| req_data | input | DATA_W | Write-back data carried by an eviction |
| inv_vec | output | NODES | One-cycle invalidate pulse per target node |
| fetch_vec | output | NODES | One-cycle fetch pulse to the exclusive owner |
| cmd_addr | output | AW | Block that the commands refer to |
| ack_vec | input | NODES | Acknowledgement pulse per node |
| ack_data | input | DATA_W | Dirty data returned by an exclusive owner |
| done_valid | output | 1 | Completion pulse |
| done_node | output | NID_W | Node whose request completed |
| done_addr | output | AW | Block of the completed request |
| done_data | output | DATA_W | Block data for read and write misses |

## Verification
The bench focuses on the transitions out of the exclusive state. A controller that skipped the fetch or the owner's write-back would hand out stale memory on a read or write miss, and would later return that stale value after an eviction. Write misses are checked against the exact invalidate set: a design that invalidated the writer itself, missed a sharer, or kept a node that had evicted would send the wrong vector. Acknowledgements arrive with random, staggered delays, so completing on the first acknowledgement instead of the last shows up as an early `done_valid`. Evictions by nodes that hold nothing are mixed in, and a controller that cleared or rewrote the entry on such a notice would later issue the wrong commands or return the wrong data.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;

   typedef enum logic [1:0] {
      BLK_UNCACHED = 2'd0,
      BLK_SHARED   = 2'd1,
      BLK_EXCL     = 2'd2
   } blk_state_e;

   typedef enum logic [1:0] {
      OP_RDMISS = 2'd0,
      OP_WRMISS = 2'd1,
      OP_EVICT  = 2'd2
   } req_op_e;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_EXEC  = 2'd1,
      CS_FETCH = 2'd2,
      CS_INV   = 2'd3
   } ctrl_st_e;

endpackage

// File: rtl/dircoh_dir.sv
module dircoh_dir
   import dircoh_pkg::*;
#(
   parameter int NODES = 4,
   parameter int NBLK  = 16,
   localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    rd_addr,
   output blk_state_e       rd_state,
   output logic [NODES-1:0] rd_shr,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  blk_state_e       wr_state,
   input  logic [NODES-1:0] wr_shr
);

   blk_state_e       st_q  [NBLK];
   logic [NODES-1:0] shr_q [NBLK];

   assign rd_state = st_q[rd_addr];
   assign rd_shr   = shr_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NBLK; i++) begin
            st_q[i]  <= BLK_UNCACHED;
            shr_q[i] <= '0;
         end
      end else if (wr_en) begin
         st_q[wr_addr]  <= wr_state;
         shr_q[wr_addr] <= wr_shr;
      end
   end

endmodule

// File: rtl/dircoh_mem.sv
module dircoh_mem #(
   parameter int NBLK           = 16,
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] word_q [NBLK];

   assign rd_data = word_q[rd_addr];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) word_q[i] <= '0;
         end else if (wr_en) begin
            word_q[wr_addr] <= wr_data;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_en) word_q[wr_addr] <= wr_data;
      end
      logic unused_rst;
      assign unused_rst = rst_n;
   end

endmodule

// File: rtl/dircoh_ctrl.sv
module dircoh_ctrl
   import dircoh_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int NBLK   = 16,
   parameter int DATA_W = 32,
   localparam int AW    = (NBLK > 1) ? $clog2(NBLK) : 1,
   localparam int NID_W = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [NID_W-1:0]  req_node,
   input  logic [1:0]        req_op,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [NODES-1:0]  ack_vec,
   input  logic [DATA_W-1:0] ack_data,
   input  blk_state_e        dir_state,
   input  logic [NODES-1:0]  dir_shr,
   output logic              dir_we,
   output blk_state_e        dir_wstate,
   output logic [NODES-1:0]  dir_wshr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [AW-1:0]     blk_addr,
   output logic [NODES-1:0]  inv_vec,
   output logic [NODES-1:0]  fetch_vec,
   output logic              done_valid,
   output logic [NID_W-1:0]  done_node,
   output logic [AW-1:0]     done_addr,
   output logic [DATA_W-1:0] done_data
);

   ctrl_st_e          st_q, st_n;
   logic [NID_W-1:0]  node_q;
   req_op_e           op_q;
   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] data_q;
   logic [NODES-1:0]  pend_q, pend_n;
   logic              wasx_q, wasx_n;

   logic [NODES-1:0]  req_bit, others, left_after, shr_less;
   logic              fin;
   logic [DATA_W-1:0] fin_data;
   logic [NODES-1:0]  inv_n, fetch_n;
   logic              accept;

   assign req_ready = (st_q == CS_IDLE) && !done_valid;
   assign accept    = req_valid && req_ready;
   assign blk_addr  = addr_q;
   assign req_bit   = NODES'(1) << node_q;
   assign others    = dir_shr & ~req_bit;
   assign shr_less  = dir_shr & ~req_bit;
   assign left_after = pend_q & ~ack_vec;

   always_comb begin
      st_n       = st_q;
      pend_n     = pend_q;
      wasx_n     = wasx_q;
      dir_we     = 1'b0;
      dir_wstate = dir_state;
      dir_wshr   = dir_shr;
      mem_we     = 1'b0;
      mem_wdata  = data_q;
      fin        = 1'b0;
      fin_data   = mem_rdata;
      inv_n      = '0;
      fetch_n    = '0;
      unique case (st_q)
         CS_IDLE: begin
            if (accept) st_n = CS_EXEC;
         end
         CS_EXEC: begin
            unique case (op_q)
               OP_RDMISS: begin
                  if (dir_state == BLK_EXCL && others != '0) begin
                     fetch_n = dir_shr;
                     pend_n  = dir_shr;
                     st_n    = CS_FETCH;
                  end else begin
                     dir_we     = 1'b1;
                     dir_wstate = (dir_state == BLK_EXCL) ? BLK_EXCL : BLK_SHARED;
                     dir_wshr   = dir_shr | req_bit;
                     fin        = 1'b1;
                     st_n       = CS_IDLE;
                  end
               end
               OP_WRMISS: begin
                  if (others == '0) begin
                     dir_we     = 1'b1;
                     dir_wstate = BLK_EXCL;
                     dir_wshr   = req_bit;
                     fin        = 1'b1;
                     st_n       = CS_IDLE;
                  end else begin
                     inv_n  = others;
                     pend_n = others;
                     wasx_n = (dir_state == BLK_EXCL);
                     st_n   = CS_INV;
                  end
               end
               OP_EVICT: begin
                  if ((dir_shr & req_bit) != '0) begin
                     dir_we = 1'b1;
                     if (dir_state == BLK_EXCL) begin
                        mem_we     = 1'b1;
                        mem_wdata  = data_q;
                        dir_wstate = BLK_UNCACHED;
                        dir_wshr   = '0;
                     end else begin
                        dir_wshr   = shr_less;
                        dir_wstate = (shr_less == '0) ? BLK_UNCACHED : BLK_SHARED;
                     end
                  end
                  fin  = 1'b1;
                  st_n = CS_IDLE;
               end
               default: begin
                  fin  = 1'b1;
                  st_n = CS_IDLE;
               end
            endcase
         end
         CS_FETCH: begin
            if ((pend_q & ack_vec) != '0) begin
               mem_we     = 1'b1;
               mem_wdata  = ack_data;
               dir_we     = 1'b1;
               dir_wstate = BLK_SHARED;
               dir_wshr   = dir_shr | req_bit;
               fin        = 1'b1;
               fin_data   = ack_data;
               pend_n     = '0;
               st_n       = CS_IDLE;
            end
         end
         CS_INV: begin
            pend_n = left_after;
            if (left_after == '0) begin
               mem_we     = wasx_q;
               mem_wdata  = ack_data;
               fin_data   = wasx_q ? ack_data : mem_rdata;
               dir_we     = 1'b1;
               dir_wstate = BLK_EXCL;
               dir_wshr   = req_bit;
               fin        = 1'b1;
               wasx_n     = 1'b0;
               st_n       = CS_IDLE;
            end
         end
         default: st_n = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         node_q     <= '0;
         op_q       <= OP_RDMISS;
         addr_q     <= '0;
         data_q     <= '0;
         pend_q     <= '0;
         wasx_q     <= 1'b0;
         inv_vec    <= '0;
         fetch_vec  <= '0;
         done_valid <= 1'b0;
         done_node  <= '0;
         done_addr  <= '0;
         done_data  <= '0;
      end else begin
         st_q       <= st_n;
         pend_q     <= pend_n;
         wasx_q     <= wasx_n;
         inv_vec    <= inv_n;
         fetch_vec  <= fetch_n;
         done_valid <= fin;
         if (accept) begin
            node_q <= req_node;
            op_q   <= req_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
         end
         if (fin) begin
            done_node <= node_q;
            done_addr <= addr_q;
            done_data <= fin_data;
         end
      end
   end

endmodule

// File: rtl/dircoh_home.sv
module dircoh_home
   import dircoh_pkg::*;
#(
   parameter int NODES          = 4,
   parameter int NBLK           = 16,
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = (NBLK > 1) ? $clog2(NBLK) : 1,
   localparam int NID_W         = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [NID_W-1:0]  req_node,
   input  logic [1:0]        req_op,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic [NODES-1:0]  inv_vec,
   output logic [NODES-1:0]  fetch_vec,
   output logic [AW-1:0]     cmd_addr,
   input  logic [NODES-1:0]  ack_vec,
   input  logic [DATA_W-1:0] ack_data,
   output logic              done_valid,
   output logic [NID_W-1:0]  done_node,
   output logic [AW-1:0]     done_addr,
   output logic [DATA_W-1:0] done_data
);

   if (NODES < 2) begin : g_bad_nodes
      $error("dircoh_home: NODES must be at least 2");
   end
   if (NBLK < 2) begin : g_bad_nblk
      $error("dircoh_home: NBLK must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dircoh_home: DATA_W must be positive");
   end

   blk_state_e        dir_state, dir_wstate;
   logic [NODES-1:0]  dir_shr, dir_wshr;
   logic              dir_we, mem_we;
   logic [DATA_W-1:0] mem_rdata, mem_wdata;
   logic [AW-1:0]     blk_addr;

   assign cmd_addr = blk_addr;

   dircoh_dir #(.NODES(NODES), .NBLK(NBLK)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (blk_addr),
      .rd_state (dir_state),
      .rd_shr   (dir_shr),
      .wr_en    (dir_we),
      .wr_addr  (blk_addr),
      .wr_state (dir_wstate),
      .wr_shr   (dir_wshr)
   );

   dircoh_mem #(.NBLK(NBLK), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (blk_addr),
      .rd_data (mem_rdata),
      .wr_en   (mem_we),
      .wr_addr (blk_addr),
      .wr_data (mem_wdata)
   );

   dircoh_ctrl #(.NODES(NODES), .NBLK(NBLK), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_node   (req_node),
      .req_op     (req_op),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .ack_vec    (ack_vec),
      .ack_data   (ack_data),
      .dir_state  (dir_state),
      .dir_shr    (dir_shr),
      .dir_we     (dir_we),
      .dir_wstate (dir_wstate),
      .dir_wshr   (dir_wshr),
      .mem_rdata  (mem_rdata),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .blk_addr   (blk_addr),
      .inv_vec    (inv_vec),
      .fetch_vec  (fetch_vec),
      .done_valid (done_valid),
      .done_node  (done_node),
      .done_addr  (done_addr),
      .done_data  (done_data)
   );

endmodule

// File: rtl/dircoh_chk.sv
module dircoh_chk #(
   parameter int NODES = 4,
   parameter int NID_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [NID_W-1:0] req_node,
   input logic [NODES-1:0] inv_vec,
   input logic [NODES-1:0] fetch_vec,
   input logic             done_valid,
   input logic [NID_W-1:0] done_node
);

   logic [NID_W-1:0] who_q;
   logic             open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         who_q  <= '0;
         open_q <= 1'b0;
      end else begin
         if (req_valid && req_ready) begin
            who_q  <= req_node;
            open_q <= 1'b1;
         end else if (done_valid) begin
            open_q <= 1'b0;
         end
      end
   end

   // R10
   stall_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10
   ready_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> !req_ready);

   // R3
   fetch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fetch_vec));

   // R4
   inv_skips_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_vec != '0) |-> (inv_vec[who_q] == 1'b0));

   // R4
   inv_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_vec != '0) |=> (inv_vec == '0));

   // R4
   cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vec != '0) |-> (inv_vec == '0));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R11
   done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (open_q && done_node == who_q));

endmodule

bind dircoh_home dircoh_chk #(.NODES(NODES), .NID_W(NID_W)) u_dircoh_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_node   (req_node),
   .inv_vec    (inv_vec),
   .fetch_vec  (fetch_vec),
   .done_valid (done_valid),
   .done_node  (done_node)
);

// File: tb/tb_dircoh_home.sv
module tb_dircoh_home;

   localparam int CLK_PERIOD = 10;
   localparam int NODES  = 4;
   localparam int NBLK   = 16;
   localparam int DATA_W = 32;
   localparam int AW     = 4;
   localparam int NID_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [NID_W-1:0]  req_node = '0;
   logic [1:0]        req_op = '0;
   logic [AW-1:0]     req_addr = '0;
   logic [DATA_W-1:0] req_data = '0;
   logic [NODES-1:0]  inv_vec, fetch_vec;
   logic [AW-1:0]     cmd_addr;
   logic [NODES-1:0]  ack_vec = '0;
   logic [DATA_W-1:0] ack_data = '0;
   logic              done_valid;
   logic [NID_W-1:0]  done_node;
   logic [AW-1:0]     done_addr;
   logic [DATA_W-1:0] done_data;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   // bench model: 0 uncached, 1 shared, 2 exclusive
   logic [1:0]        m_st    [NBLK];
   logic [NODES-1:0]  m_shr   [NBLK];
   logic [DATA_W-1:0] m_mem   [NBLK];
   logic [DATA_W-1:0] m_dirty [NBLK];

   always #(CLK_PERIOD/2) clk = ~clk;

   dircoh_home dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_node(req_node), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .inv_vec(inv_vec), .fetch_vec(fetch_vec), .cmd_addr(cmd_addr),
      .ack_vec(ack_vec), .ack_data(ack_data), .done_valid(done_valid),
      .done_node(done_node), .done_addr(done_addr), .done_data(done_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic logic [NODES-1:0] nbit(input int n);
      return NODES'(1) << n;
   endfunction

   task automatic do_req(input int node, input int op, input int addr,
                         input logic [DATA_W-1:0] wdata, input string tg);
      logic [NODES-1:0]  rb, exp_inv, exp_fetch, seen_inv, seen_fetch, outst, tgt;
      logic [DATA_W-1:0] exp_data, send, ackd;
      string             dtag, itag, ftag;
      bit                chk_data, got, set_now;
      int                dl [NODES];
      rb = nbit(node);
      exp_inv = '0; exp_fetch = '0; chk_data = 1'b1;
      send = wdata; ackd = m_dirty[addr]; exp_data = m_mem[addr];
      dtag = "R2"; itag = "R4"; ftag = "R3";
      case (op)
         0: begin
            if (m_st[addr] == 2 && m_shr[addr] != rb) begin
               exp_fetch = m_shr[addr]; exp_data = m_dirty[addr];
               m_mem[addr] = m_dirty[addr]; dtag = "R3";
            end
            m_st[addr] = 1; m_shr[addr] = m_shr[addr] | rb;
         end
         1: begin
            exp_inv = m_shr[addr] & ~rb;
            if (m_st[addr] == 2 && exp_inv != '0) begin
               exp_data = m_dirty[addr]; m_mem[addr] = m_dirty[addr]; dtag = "R5";
            end else dtag = "R6";
            m_st[addr] = 2; m_shr[addr] = rb; m_dirty[addr] = wdata;
         end
         default: begin
            chk_data = 1'b0;
            if ((m_shr[addr] & rb) != '0) begin
               if (m_st[addr] == 2) begin
                  send = m_dirty[addr]; m_mem[addr] = send;
                  m_st[addr] = 0; m_shr[addr] = '0;
               end else begin
                  m_shr[addr] = m_shr[addr] & ~rb;
                  m_st[addr] = (m_shr[addr] == '0) ? 2'd0 : 2'd1;
               end
            end
         end
      endcase
      if (tg != "") begin dtag = tg; itag = tg; ftag = tg; end

      @(negedge clk);
      chk(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 1);
      req_node = NID_W'(node); req_op = 2'(op); req_addr = AW'(addr);
      req_data = send; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10 stall", 32'(req_ready), 0);

      seen_inv = '0; seen_fetch = '0; outst = '0; got = 1'b0;
      for (int k = 0; k < NODES; k++) dl[k] = 0;
      for (int c = 0; c < 40 && !got; c++) begin
         if (c > 0) @(negedge clk);
         ack_vec = '0; set_now = 1'b0;
         if (inv_vec != '0 || fetch_vec != '0) begin
            seen_inv   = seen_inv | inv_vec;
            seen_fetch = seen_fetch | fetch_vec;
            tgt = inv_vec | fetch_vec;
            for (int k = 0; k < NODES; k++)
               if (tgt[k]) dl[k] = int'($urandom % 4);
            outst = outst | tgt;
         end
         if (done_valid) begin
            got = 1'b1;
            chk(outst == '0, "R12 early completion", 32'(outst), 0);
            chk(done_node == NID_W'(node), "R11 node", 32'(done_node), 32'(node));
            chk(done_addr == AW'(addr), "R11 addr", 32'(done_addr), 32'(addr));
            chk(seen_inv == exp_inv, itag, 32'(seen_inv), 32'(exp_inv));
            chk(seen_fetch == exp_fetch, ftag, 32'(seen_fetch), 32'(exp_fetch));
            if (chk_data) chk(done_data == exp_data, dtag, done_data, exp_data);
         end else begin
            for (int k = 0; k < NODES; k++) begin
               if (outst[k]) begin
                  if (dl[k] == 0) begin
                     ack_vec[k] = 1'b1; outst[k] = 1'b0; set_now = 1'b1;
                  end else dl[k]--;
               end
            end
            ack_data = (set_now && (exp_fetch != '0 || dtag == "R5" || tg != "")) ? ackd : $urandom;
            if (exp_fetch != '0 || (op == 1 && ackd == m_mem[addr])) ack_data = ackd;
         end
      end
      ack_vec = '0;
      if (!got) chk(1'b0, "R11 timeout", 0, 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int b = 0; b < NBLK; b++) begin
         m_st[b] = 0; m_shr[b] = '0; m_mem[b] = '0; m_dirty[b] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
      chk(inv_vec == '0, "R1 inv", 32'(inv_vec), 0);
      chk(fetch_vec == '0, "R1 fetch", 32'(fetch_vec), 0);
      chk(done_valid == 1'b0, "R1 done", 32'(done_valid), 0);
      for (int b = 0; b < NBLK; b++) do_req(b % NODES, 0, b, '0, "R1");
      for (int b = 0; b < NBLK; b++) do_req(b % NODES, 2, b, '0, "R8");

      // directed sequence on block 3
      do_req(0, 0, 3, '0, "R2");
      do_req(1, 0, 3, '0, "R2");
      do_req(2, 1, 3, 32'hA5A5_0001, "R4");
      do_req(1, 0, 3, '0, "R3");
      do_req(3, 1, 3, 32'hC0DE_0002, "R5");
      do_req(3, 2, 3, '0, "R7");
      do_req(0, 0, 3, '0, "R7");
      do_req(1, 2, 3, 32'hDEAD_BEEF, "R9");
      do_req(0, 1, 3, 32'h1234_5678, "R9");
      do_req(2, 0, 3, '0, "R3");
      do_req(0, 2, 3, 32'h0, "R8");
      do_req(1, 1, 3, 32'h7777_0003, "R8");
      do_req(1, 2, 3, '0, "R7");
      do_req(2, 1, 3, 32'h4444_0004, "R6");
      // many sharers, staggered acknowledgements
      do_req(0, 0, 5, '0, "R2");
      do_req(1, 0, 5, '0, "R2");
      do_req(2, 0, 5, '0, "R2");
      do_req(3, 1, 5, 32'h5555_0005, "R12");

      for (int t = 0; t < 500; t++) begin
         int n, o, a;
         n = int'($urandom % NODES);
         o = int'($urandom % 3);
         a = int'($urandom % 6);
         if (o != 2 && m_st[a] == 2 && m_shr[a] == nbit(n)) o = 2;
         do_req(n, o, a, $urandom, "");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule